// File: doc/BRIEF.md
# Double-Edge Input Capture with Half-Rate Conversion

This block is the receive register path of one memory-interface I/O group. Each data pin is sampled on both edges of a strobe-derived capture clock. The two bits from one strobe period are joined into a pair in the strobe domain. The pair is then registered into a zero-phase resync clock domain. A divide-by-two phase folds two consecutive pairs into one four-bit word per pin, and the core reads that word at half the resync rate.

Static parameters set the configuration. One parameter swaps the strobe edges, which suits interfaces that need the strobe inverted. Another removes the resync register stage. A third makes the divider follow an external phase input instead of running on its own. The divider exports its phase, so one group can set the divided phase of a neighbouring group and a wider bus keeps a single word boundary. A run-time select input lets the core bypass the pipeline and see the raw pin level.

Top module: `ddr_input_halfrate`

## Requirements
- R1: While rstN is low, every capture, resync, hold and word register is cleared. Directly after reset, with dataOutSel low, dataOut is all zero and slaveOut is 0.
- R2: With INVERT_STROBE=0, a pin's rising-phase bit is sampled on the rising strobe edge and its falling-phase bit on the following falling edge. At the next rising edge both bits are registered together as one pair, so the falling bit passes through one rising-edge retiming register.
- R3: With RESYNC_BYPASS=0, each pair is registered once more on the rising resyncClk edge before the half-rate stage reads it.
- R4: For each pin p the word fields are: bit 4p = rising bit of the older pair, 4p+1 = falling bit of the older pair, 4p+2 = rising bit of the newer pair, 4p+3 = falling bit of the newer pair. Up to six pins (PINS from 1 to 6) share one divider and all of them update on the same edge.
- R5: The word changes only on a resyncClk edge at which the divider phase was 1. On that edge it takes the pair then sitting in the resync register as the newer pair, and the pair held from the previous edge as the older pair.
- R6: With USE_MASTER=0, the divider phase is 0 after reset and toggles on every resyncClk rising edge. slaveOut carries this phase.
- R7: With USE_MASTER=1, the divider phase is taken from masterIn and is not free-running. slaveOut then equals masterIn, so a follower connected to a leader's slaveOut updates on the same edges as the leader.
- R8: dataOutSel can change at run time. While it is 1, bit 4p of dataOut equals pinIn[p] with no register in the path, and bits 4p+1 to 4p+3 are 0. While it is 0, dataOut is the half-rate word.
- R9: With INVERT_STROBE=1, the roles of the strobe edges are swapped: the rising-phase bit is sampled on the falling strobe edge, and pairing and retiming use the falling edge.
- R10: With RESYNC_BYPASS=1, the half-rate stage reads the strobe-domain pair directly. Each word then holds pairs that are one resync cycle younger than with the resync stage present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobeIn | input | 1 | Strobe-derived capture clock |
| resyncClk | input | 1 | Zero-phase resync clock; the half-rate word is timed from it |
| rstN | input | 1 | Asynchronous active-low reset for all registers |
| masterIn | input | 1 | External divider phase, used when USE_MASTER=1 |
| dataOutSel | input | 1 | Run-time select: 1 = direct pin level, 0 = half-rate word |
| pinIn | input | PINS | Pin data |
| dataOut | output | 4*PINS | Data to the core, four bits per pin |
| slaveOut | output | 1 | Divider phase, for chaining into a neighbour's masterIn |

## Verification
The bench builds four copies of the block, each with PINS=6, so every word carries the largest group one divider may serve. The reference copy uses its own divider. A second copy has INVERT_STROBE=1 and is fed the complemented strobe, so it must produce exactly the same words as the reference; this exercises the swapped edge roles. A third copy has USE_MASTER=1 and is driven from the reference's slaveOut, which brings the chained phase and its shared word boundary within reach. A fourth copy has RESYNC_BYPASS=1, which exposes the one-cycle-shorter pair timing.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

  localparam int unsigned BITS_PER_PIN = 4;
  localparam int unsigned MAX_PINS     = 6;

  // strobes from the divider control to the datapath
  typedef struct packed {
    logic loadHold;   // park the current pair as the older half
    logic loadWord;   // assemble the four-bit word
  } hrCtrl_t;

endpackage

// File: rtl/ddr_cap_ctrl.sv
module ddr_cap_ctrl
  import ddr_cap_pkg::*;
#(
  parameter bit USE_MASTER = 1'b0
) (
  input  logic    resyncClk,
  input  logic    rstN,
  input  logic    masterIn,
  output hrCtrl_t ctrl,
  output logic    slaveOut
);

  logic phase;

  generate
    if (USE_MASTER) begin : g_follow
      // phase comes from the neighbouring divider
      assign phase = masterIn;
    end else begin : g_own
      logic phaseQ;
      logic unusedMasterIn;
      assign unusedMasterIn = masterIn;
      always_ff @(posedge resyncClk or negedge rstN) begin
        if (!rstN) phaseQ <= 1'b0;
        else       phaseQ <= ~phaseQ;
      end
      assign phase = phaseQ;
    end
  endgenerate

  always_comb begin
    ctrl.loadHold = ~phase;
    ctrl.loadWord = phase;
  end

  assign slaveOut = phase;

endmodule

// File: rtl/ddr_cap_datapath.sv
module ddr_cap_datapath
  import ddr_cap_pkg::*;
#(
  parameter int unsigned PINS          = 4,
  parameter bit          INVERT_STROBE = 1'b0,
  parameter bit          RESYNC_BYPASS = 1'b0,
  localparam int unsigned WORD_W       = PINS * BITS_PER_PIN
) (
  input  logic              strobeIn,
  input  logic              resyncClk,
  input  logic              rstN,
  input  hrCtrl_t           ctrl,
  input  logic              dataOutSel,
  input  logic [PINS-1:0]   pinIn,
  output logic [WORD_W-1:0] dataOut
);

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      logic riseCap, fallCap;
      logic pairRise, pairFall;
      logic syncRise, syncFall;
      logic holdRise, holdFall;
      logic [BITS_PER_PIN-1:0] wordQ;

      // capture on both strobe edges; pairing happens on the leading edge
      if (INVERT_STROBE) begin : g_inv
        always_ff @(negedge strobeIn or negedge rstN) begin
          if (!rstN) begin
            riseCap  <= 1'b0;
            pairRise <= 1'b0;
            pairFall <= 1'b0;
          end else begin
            riseCap  <= pinIn[p];
            pairRise <= riseCap;
            pairFall <= fallCap;
          end
        end
        always_ff @(posedge strobeIn or negedge rstN) begin
          if (!rstN) fallCap <= 1'b0;
          else       fallCap <= pinIn[p];
        end
      end else begin : g_true
        always_ff @(posedge strobeIn or negedge rstN) begin
          if (!rstN) begin
            riseCap  <= 1'b0;
            pairRise <= 1'b0;
            pairFall <= 1'b0;
          end else begin
            riseCap  <= pinIn[p];
            pairRise <= riseCap;
            pairFall <= fallCap;
          end
        end
        always_ff @(negedge strobeIn or negedge rstN) begin
          if (!rstN) fallCap <= 1'b0;
          else       fallCap <= pinIn[p];
        end
      end

      // resync stage, optionally removed
      if (RESYNC_BYPASS) begin : g_nosync
        assign syncRise = pairRise;
        assign syncFall = pairFall;
      end else begin : g_sync
        always_ff @(posedge resyncClk or negedge rstN) begin
          if (!rstN) begin
            syncRise <= 1'b0;
            syncFall <= 1'b0;
          end else begin
            syncRise <= pairRise;
            syncFall <= pairFall;
          end
        end
      end

      // half-rate fold: older pair low, newer pair high
      always_ff @(posedge resyncClk or negedge rstN) begin
        if (!rstN) begin
          holdRise <= 1'b0;
          holdFall <= 1'b0;
          wordQ    <= '0;
        end else begin
          if (ctrl.loadHold) begin
            holdRise <= syncRise;
            holdFall <= syncFall;
          end
          if (ctrl.loadWord) begin
            wordQ <= {syncFall, syncRise, holdFall, holdRise};
          end
        end
      end

      assign dataOut[p*BITS_PER_PIN +: BITS_PER_PIN] =
        dataOutSel ? {{(BITS_PER_PIN-1){1'b0}}, pinIn[p]} : wordQ;
    end
  endgenerate

endmodule

// File: rtl/ddr_input_halfrate.sv
module ddr_input_halfrate
  import ddr_cap_pkg::*;
#(
  parameter int unsigned PINS          = 4,
  parameter bit          INVERT_STROBE = 1'b0,
  parameter bit          RESYNC_BYPASS = 1'b0,
  parameter bit          USE_MASTER    = 1'b0
) (
  input  logic                         strobeIn,
  input  logic                         resyncClk,
  input  logic                         rstN,
  input  logic                         masterIn,
  input  logic                         dataOutSel,
  input  logic [PINS-1:0]              pinIn,
  output logic [PINS*BITS_PER_PIN-1:0] dataOut,
  output logic                         slaveOut
);

  hrCtrl_t ctrl;

  ddr_cap_ctrl #(
    .USE_MASTER(USE_MASTER)
  ) ctrl_i (
    .resyncClk(resyncClk),
    .rstN     (rstN),
    .masterIn (masterIn),
    .ctrl     (ctrl),
    .slaveOut (slaveOut)
  );

  ddr_cap_datapath #(
    .PINS         (PINS),
    .INVERT_STROBE(INVERT_STROBE),
    .RESYNC_BYPASS(RESYNC_BYPASS)
  ) dp_i (
    .strobeIn  (strobeIn),
    .resyncClk (resyncClk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dataOutSel(dataOutSel),
    .pinIn     (pinIn),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/ddr_cap_checker.sv
module ddr_cap_checker #(
  parameter int unsigned PINS       = 4,
  parameter bit          USE_MASTER = 1'b0
) (
  input logic                resyncClk,
  input logic                rstN,
  input logic                masterIn,
  input logic                dataOutSel,
  input logic [PINS-1:0]     pinIn,
  input logic [PINS*4-1:0]   dataOut,
  input logic                slaveOut
);

  logic armed;
  logic bypassOk;

  always_ff @(posedge resyncClk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    bypassOk = 1'b1;
    for (int p = 0; p < int'(PINS); p++) begin
      if (dataOut[p*4+1 +: 3] != 3'b000) bypassOk = 1'b0;
      if (dataOut[p*4] != pinIn[p])      bypassOk = 1'b0;
    end
  end

  // R6: free-running divider alternates every edge
  p_divider_toggle_r6: assert property (@(posedge resyncClk) disable iff (!rstN)
    (!USE_MASTER && armed) |-> (slaveOut != $past(slaveOut)));

  // R7: follower takes its phase from masterIn
  p_master_follow_r7: assert property (@(posedge resyncClk) disable iff (!rstN)
    USE_MASTER |-> (slaveOut == masterIn));

  // R5: word holds across an edge that saw phase 0
  p_word_hold_r5: assert property (@(posedge resyncClk) disable iff (!rstN)
    (armed && !dataOutSel && !$past(dataOutSel) && !$past(slaveOut)) |-> $stable(dataOut));

  // R8: bypass select shows the pin level in bit 0 of each field
  p_bypass_view_r8: assert property (@(posedge resyncClk) disable iff (!rstN)
    dataOutSel |-> bypassOk);

endmodule

bind ddr_input_halfrate ddr_cap_checker #(
  .PINS      (PINS),
  .USE_MASTER(USE_MASTER)
) chk_i (
  .resyncClk (resyncClk),
  .rstN      (rstN),
  .masterIn  (masterIn),
  .dataOutSel(dataOutSel),
  .pinIn     (pinIn),
  .dataOut   (dataOut),
  .slaveOut  (slaveOut)
);

// File: tb/ddr_input_halfrate_tb.sv
`timescale 1ns/1ps
module ddr_input_halfrate_tb_top;

  localparam int NP   = 6;
  localparam int WW   = NP * 4;
  localparam int NCYC = 120;

  logic strobe, resyncClk, rstN, dataOutSel;
  logic [NP-1:0] pinIn;
  logic [WW-1:0] outRef, outInv, outFol, outByp;
  logic slvRef, slvInv, slvFol, slvByp;

  int checks = 0;
  int errors = 0;

  // scoreboard queue: one {fall,rise} pair per strobe period
  logic [2*NP-1:0] pairQ [$];

  ddr_input_halfrate #(.PINS(NP)) dut_i (
    .strobeIn(strobe), .resyncClk(resyncClk), .rstN(rstN), .masterIn(1'b0),
    .dataOutSel(dataOutSel), .pinIn(pinIn), .dataOut(outRef), .slaveOut(slvRef));

  ddr_input_halfrate #(.PINS(NP), .INVERT_STROBE(1'b1)) inv_i (
    .strobeIn(~strobe), .resyncClk(resyncClk), .rstN(rstN), .masterIn(1'b0),
    .dataOutSel(dataOutSel), .pinIn(pinIn), .dataOut(outInv), .slaveOut(slvInv));

  ddr_input_halfrate #(.PINS(NP), .USE_MASTER(1'b1)) fol_i (
    .strobeIn(strobe), .resyncClk(resyncClk), .rstN(rstN), .masterIn(slvRef),
    .dataOutSel(dataOutSel), .pinIn(pinIn), .dataOut(outFol), .slaveOut(slvFol));

  ddr_input_halfrate #(.PINS(NP), .RESYNC_BYPASS(1'b1)) byp_i (
    .strobeIn(strobe), .resyncClk(resyncClk), .rstN(rstN), .masterIn(1'b0),
    .dataOutSel(dataOutSel), .pinIn(pinIn), .dataOut(outByp), .slaveOut(slvByp));

  // 200 MHz resync clock, rising edges at 2.5 + 5n
  initial begin
    resyncClk = 1'b0;
    forever #2.5 resyncClk = ~resyncClk;
  end

  // strobe leads resync by a quarter period: rising at 1.25 + 5m
  initial begin
    strobe = 1'b0;
    #1.25;
    forever begin
      strobe = 1'b1; #2.5;
      strobe = 1'b0; #2.5;
    end
  end

  // driver: rising-phase bit from 5m, falling-phase bit from 5m+3
  initial begin
    pinIn = '0;
    for (int m = 0; m < NCYC + 4; m++) begin
      logic [NP-1:0] r, f;
      r = NP'($urandom);
      f = NP'($urandom);
      pairQ.push_back({f, r});
      pinIn = r; #3;
      pinIn = f; #2;
    end
  end

  function automatic logic [WW-1:0] mkWord(logic [2*NP-1:0] older, logic [2*NP-1:0] newer);
    logic [WW-1:0] w;
    for (int p = 0; p < NP; p++) begin
      w[4*p]   = older[p];
      w[4*p+1] = older[NP+p];
      w[4*p+2] = newer[p];
      w[4*p+3] = newer[NP+p];
    end
    return w;
  endfunction

  task automatic check(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // monitor: samples at 4 + 5n, between edges
  initial begin
    rstN = 1'b0;
    dataOutSel = 1'b0;
    #4;
    for (int n = 0; n < NCYC; n++) begin
      if (n == 3) begin
        check("R1 word", outRef, '0);
        check("R1 phase", WW'(slvRef), '0);
      end
      if (n >= 4) begin
        check("R6 phase", WW'(slvRef), WW'((n - 3) % 2));
        check("R7 follower phase", WW'(slvFol), WW'(slvRef));
      end
      if (n >= 60 && n <= 64) begin
        logic [WW-1:0] e;
        e = '0;
        for (int p = 0; p < NP; p++) e[4*p] = pairQ[n][NP+p];
        check("R8 bypass view", outRef, e);
        check("R8 bypass view byp", outByp, e);
      end else if (n >= 9) begin
        int u;
        u = (n % 2 == 1) ? n : n - 1;
        check("R4 R5 R3 R2 word", outRef, mkWord(pairQ[u-3], pairQ[u-2]));
        check("R9 inverted strobe", outInv, mkWord(pairQ[u-3], pairQ[u-2]));
        check("R7 follower word", outFol, mkWord(pairQ[u-3], pairQ[u-2]));
        check("R10 resync bypass", outByp, mkWord(pairQ[u-2], pairQ[u-1]));
      end
      if (n == 3) begin
        #2 rstN = 1'b1;
        #3;
      end else begin
        if (n == 59) begin #0.5 dataOutSel = 1'b1; #4.5; end
        else if (n == 64) begin #0.5 dataOutSel = 1'b0; #4.5; end
        else #5;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t: actual running expected done", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule